// File: doc/BRIEF.md
# Register-Mapped Dual-Channel Stream Controller

This block connects a simple processor register bus to two independent streaming channels. The receive channel takes words from an upstream source. The transmit channel sends words to a downstream sink. Both channels use a valid/ready handshake with an end-of-stream marker. Each channel buffers its traffic in a power-of-two FIFO. Every FIFO entry holds a 32-bit data word, a last flag and a 4-bit routing tag. Software moves words through the FIFOs by reading and writing two data offsets. It attaches a destination tag to transmit words through a routing register, and it recovers the source tag and the last flag of each received word after reading that word.

A control register turns the block on and off, flushes either FIFO, and reports FIFO levels and the depth of each FIFO. It also selects which FIFO-level conditions raise the receive interrupt and the transmit interrupt. Both interrupts are level outputs. Turning the block off empties both FIFOs and holds both stream interfaces idle.

The bus takes one request per cycle: a word offset, a write strobe, write data and a read strobe. Read data is registered and appears the cycle after the read request.

Top module: `stream_link_ctrl`

## Requirements
- R1: An RX word is accepted only in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only while the block is enabled and the RX FIFO is not full. `tx_valid` is high only while the block is enabled and the TX FIFO holds a word.
- R2: A write to offset 0x8 queues a TX word with last=0. A write to offset 0xC queues it with last=1. Each queued word carries the destination tag held in routing bits 3:0 at the time of the write. Words leave on `tx_data`/`tx_last`/`tx_tag` in the order they were written, one for each cycle where `tx_valid` and `tx_ready` are both high.
- R3: A read request at offset 0x8 or 0xC pops the oldest RX word and returns its data on `bus_rdata` in the following cycle. After that, control bit 4 shows the popped word's last flag and routing bits 7:4 show its source tag. Routing bits 31:8 read as zero.
- R4: A TX data write while the TX FIFO is full is discarded. The FIFO contents and order stay unchanged.
- R5: A data read while the RX FIFO is empty does not pop. It returns the data of the most recently popped word, or zero if no word has been popped since the block was last enabled.
- R6: Control status bits: 8 is RX empty, 9 is RX at least half full, 10 is RX full, 11 is TX empty, 12 is TX at least half full, 13 is TX full. "At least half full" means the fill count is at least half the depth. For a depth of 1 it equals full.
- R7: Control bits 27:24 read log2 of the RX depth and bits 31:28 read log2 of the TX depth. Bits 21:16 read back the interrupt selects, bit 0 reads back the enable, and all other bits read zero.
- R8: Writing the control register with bit 1 set flushes the RX FIFO. Writing it with bit 2 set flushes the TX FIFO. Neither bit is stored, so both always read zero.
- R9: Writing the control register with bit 0 clear flushes both FIFOs in the same cycle and clears the popped-word data, last flag and source tag. While disabled, `rx_ready`, `tx_valid` and both interrupts stay low.
- R10: `irq_rx` is high when enabled and at least one selected condition holds: bit 16 selects RX not empty, bit 17 selects RX at least half full, bit 18 selects RX full.
- R11: `irq_tx` is high when enabled and at least one selected condition holds: bit 19 selects TX empty, bit 20 selects TX below half full, bit 21 selects TX not full.
- R12: After reset the control register reads disabled, both FIFOs empty and all interrupt selects clear. The routing register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Word offset (byte address bits 3:2) |
| bus_we | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| rx_data | input | 32 | Incoming stream data |
| rx_tag | input | 4 | Incoming source tag |
| rx_valid | input | 1 | Incoming word valid |
| rx_last | input | 1 | Incoming word ends a stream |
| rx_ready | output | 1 | Block can accept an incoming word |
| tx_data | output | 32 | Outgoing stream data |
| tx_tag | output | 4 | Outgoing destination tag |
| tx_valid | output | 1 | Outgoing word valid |
| tx_last | output | 1 | Outgoing word ends a stream |
| tx_ready | input | 1 | Sink can accept the outgoing word |
| irq_rx | output | 1 | Receive interrupt level |
| irq_tx | output | 1 | Transmit interrupt level |

## Verification
The assertions check on every cycle that a full FIFO is never overwritten and an empty one is never popped, and that a flush or a disable leaves the FIFOs empty on the next edge. They also check that the handshake outputs and the interrupts stay low while the block is off, and that the popped-word metadata follows the head of the RX FIFO. Only the bench scenarios can show end-to-end properties. These are word order and tag association across both FIFOs, the value an empty read returns, the layout of every control field, and the interrupt level under each mix of selects and fill levels. The bench compares all of these against a queue model through the ports.

// File: rtl/slk_pkg.sv
package slk_pkg;

  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;

  typedef struct packed {
    logic              last;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } slk_word_t;

  typedef enum logic [1:0] {
    OFS_CTRL      = 2'd0,
    OFS_ROUTE     = 2'd1,
    OFS_DATA      = 2'd2,
    OFS_DATA_LAST = 2'd3
  } slk_ofs_e;

  // control register bit positions
  localparam int B_EN       = 0;
  localparam int B_RX_FLUSH = 1;
  localparam int B_TX_FLUSH = 2;
  localparam int B_RD_LAST  = 4;
  localparam int B_RX_EMPTY = 8;
  localparam int B_RX_HALF  = 9;
  localparam int B_RX_FULL  = 10;
  localparam int B_TX_EMPTY = 11;
  localparam int B_TX_HALF  = 12;
  localparam int B_TX_FULL  = 13;
  localparam int B_IE_LO    = 16;
  localparam int B_IE_HI    = 21;
  localparam int B_RXLOG_LO = 24;
  localparam int B_TXLOG_LO = 28;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } slk_lvl_t;

endpackage

// File: rtl/slk_rst_sync.sv
module slk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/slk_fifo.sv
module slk_fifo
  import slk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  slk_word_t wdata,
  input  logic      pop,
  output slk_word_t head,
  output slk_lvl_t  lvl
);

  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int HALF_LVL = (DEPTH > 1) ? DEPTH / 2 : 1;

  slk_word_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign lvl.empty = (cnt_q == '0);
  assign lvl.full  = (cnt_q == CNT_W'(DEPTH));
  assign lvl.half  = (cnt_q >= CNT_W'(HALF_LVL));

  assign do_push = push & ~lvl.full & ~flush;
  assign do_pop  = pop & ~lvl.empty & ~flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  assign head = mem[rd_ptr_q];

  // full FIFO keeps its level when a push is refused
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl.full && push && !pop && !flush) |=> (lvl.full && $stable(cnt_q)));

  // popping an empty FIFO leaves it empty
  assert_empty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl.empty && pop && !push && !flush) |=> lvl.empty);

  // flush empties the FIFO on the next edge
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> lvl.empty);

  assert_half_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl.full |-> lvl.half);

endmodule

// File: rtl/slk_irq.sv
module slk_irq
  import slk_pkg::*;
(
  input  logic     en,
  input  logic [5:0] sel,
  input  slk_lvl_t rx_lvl,
  input  slk_lvl_t tx_lvl,
  output logic     irq_rx,
  output logic     irq_tx
);

  logic [2:0] rx_cond, tx_cond;

  assign rx_cond = {rx_lvl.full, rx_lvl.half, ~rx_lvl.empty};
  assign tx_cond = {~tx_lvl.full, ~tx_lvl.half, tx_lvl.empty};

  assign irq_rx = en & |(rx_cond & sel[2:0]);
  assign irq_tx = en & |(tx_cond & sel[5:3]);

endmodule

// File: rtl/stream_link_ctrl.sv
module stream_link_ctrl
  import slk_pkg::*;
#(
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [3:2]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [TAG_W-1:0]  rx_tag,
  input  logic              rx_valid,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [TAG_W-1:0]  tx_tag,
  output logic              tx_valid,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              irq_rx,
  output logic              irq_tx
);

  localparam int RX_LOG = $clog2(RX_DEPTH);
  localparam int TX_LOG = $clog2(TX_DEPTH);
  localparam int IE_W   = B_IE_HI - B_IE_LO + 1;

  logic rst_n;
  slk_ofs_e ofs;

  // configuration and popped-word state
  logic              en_q, en_d;
  logic [IE_W-1:0]   ie_q, ie_d;
  logic [TAG_W-1:0]  dest_q, dest_d;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;
  logic [TAG_W-1:0]  rd_src_q, rd_src_d;
  logic              rd_last_q, rd_last_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic ctrl_wr, route_wr, data_wr, data_rd;
  logic rx_flush, tx_flush, rx_push, tx_pop;
  slk_word_t rx_in, rx_head, tx_in, tx_head;
  slk_lvl_t  rx_lvl, tx_lvl;
  logic [DATA_W-1:0] ctrl_view, route_view;

  slk_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // ---------------- bus decode ----------------
  assign ofs      = slk_ofs_e'(bus_addr);
  assign ctrl_wr  = bus_we & (ofs == OFS_CTRL);
  assign route_wr = bus_we & (ofs == OFS_ROUTE);
  assign data_wr  = bus_we & ((ofs == OFS_DATA) | (ofs == OFS_DATA_LAST));
  assign data_rd  = bus_re & ((ofs == OFS_DATA) | (ofs == OFS_DATA_LAST));

  assign en_d   = ctrl_wr ? bus_wdata[B_EN] : en_q;
  assign ie_d   = ctrl_wr ? bus_wdata[B_IE_HI:B_IE_LO] : ie_q;
  assign dest_d = route_wr ? bus_wdata[TAG_W-1:0] : dest_q;

  assign rx_flush = ~en_d | (ctrl_wr & bus_wdata[B_RX_FLUSH]);
  assign tx_flush = ~en_d | (ctrl_wr & bus_wdata[B_TX_FLUSH]);

  // ---------------- stream edges ----------------
  assign rx_ready = en_q & ~rx_lvl.full & ~rx_flush;
  assign rx_push  = rx_valid & rx_ready;
  assign rx_in    = '{last: rx_last, tag: rx_tag, data: rx_data};

  assign tx_in    = '{last: (ofs == OFS_DATA_LAST), tag: dest_q, data: bus_wdata};
  assign tx_valid = en_q & ~tx_lvl.empty;
  assign tx_pop   = tx_valid & tx_ready;
  assign tx_data  = tx_head.data;
  assign tx_tag   = tx_head.tag;
  assign tx_last  = tx_head.last;

  slk_fifo #(.DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rx_flush),
    .push  (rx_push),
    .wdata (rx_in),
    .pop   (data_rd),
    .head  (rx_head),
    .lvl   (rx_lvl)
  );

  slk_fifo #(.DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_flush),
    .push  (data_wr),
    .wdata (tx_in),
    .pop   (tx_pop),
    .head  (tx_head),
    .lvl   (tx_lvl)
  );

  slk_irq u_irq (
    .en     (en_q),
    .sel    (ie_q),
    .rx_lvl (rx_lvl),
    .tx_lvl (tx_lvl),
    .irq_rx (irq_rx),
    .irq_tx (irq_tx)
  );

  // ---------------- popped-word tracking ----------------
  always_comb begin
    rd_data_d = rd_data_q;
    rd_src_d  = rd_src_q;
    rd_last_d = rd_last_q;
    if (!en_d) begin
      rd_data_d = '0;
      rd_src_d  = '0;
      rd_last_d = 1'b0;
    end else if (data_rd && !rx_lvl.empty && !rx_flush) begin
      rd_data_d = rx_head.data;
      rd_src_d  = rx_head.tag;
      rd_last_d = rx_head.last;
    end
  end

  // ---------------- read views ----------------
  always_comb begin
    ctrl_view = '0;
    ctrl_view[B_EN]       = en_q;
    ctrl_view[B_RD_LAST]  = rd_last_q;
    ctrl_view[B_RX_EMPTY] = rx_lvl.empty;
    ctrl_view[B_RX_HALF]  = rx_lvl.half;
    ctrl_view[B_RX_FULL]  = rx_lvl.full;
    ctrl_view[B_TX_EMPTY] = tx_lvl.empty;
    ctrl_view[B_TX_HALF]  = tx_lvl.half;
    ctrl_view[B_TX_FULL]  = tx_lvl.full;
    ctrl_view[B_IE_HI:B_IE_LO]         = ie_q;
    ctrl_view[B_RXLOG_LO+3:B_RXLOG_LO] = 4'(RX_LOG);
    ctrl_view[B_TXLOG_LO+3:B_TXLOG_LO] = 4'(TX_LOG);
  end

  assign route_view = {{(DATA_W-2*TAG_W){1'b0}}, rd_src_q, dest_q};

  always_comb begin
    unique case (ofs)
      OFS_CTRL:  rdata_d = ctrl_view;
      OFS_ROUTE: rdata_d = route_view;
      default:   rdata_d = rx_lvl.empty ? rd_data_q : rx_head.data;
    endcase
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      ie_q      <= '0;
      dest_q    <= '0;
      rd_data_q <= '0;
      rd_src_q  <= '0;
      rd_last_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      en_q      <= en_d;
      ie_q      <= ie_d;
      dest_q    <= dest_d;
      rd_data_q <= rd_data_d;
      rd_src_q  <= rd_src_d;
      rd_last_q <= rd_last_d;
      if (bus_re) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // ---------------- assertions ----------------
  assert_rx_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (en_q && !rx_lvl.full));

  assert_tx_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_lvl.empty);

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!rx_ready && !tx_valid && !irq_rx && !irq_tx));

  assert_off_flushed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_d |=> (rx_lvl.empty && tx_lvl.empty && !rd_last_q));

  assert_pop_meta_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && en_d && !rx_flush && !rx_lvl.empty)
      |=> (rd_last_q == $past(rx_head.last) && rd_src_q == $past(rx_head.tag)));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && en_d && rx_lvl.empty) |=> $stable(rd_data_q));

endmodule

// File: tb/sim_stream_link_ctrl.sv
module sim_stream_link_ctrl;

  localparam int RXD = 8;
  localparam int TXD = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:2]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] rx_data = '0;
  logic [3:0]  rx_tag = '0;
  logic        rx_valid = 1'b0;
  logic        rx_last = 1'b0;
  logic        rx_ready;
  logic [31:0] tx_data;
  logic [3:0]  tx_tag;
  logic        tx_valid;
  logic        tx_last;
  logic        tx_ready = 1'b0;
  logic        irq_rx, irq_tx;

  always #10 clk = ~clk;  // 50 MHz

  stream_link_ctrl #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u0 (
    .clk(clk), .rst_ni(rst_ni),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .rx_tag(rx_tag), .rx_valid(rx_valid),
    .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_tag(tx_tag), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // model state: entry = {last, tag[3:0], data[31:0]}
  logic [36:0] rxq[$];
  logic [36:0] txq[$];
  bit          m_en = 1'b0;
  logic [5:0]  m_ie = '0;
  logic [3:0]  m_dest = '0;
  logic [31:0] m_pdata = '0;
  logic [3:0]  m_psrc = '0;
  bit          m_plast = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v = '0;
    v[0]     = m_en;
    v[4]     = m_plast;
    v[8]     = (rxq.size() == 0);
    v[9]     = (rxq.size() >= RXD / 2);
    v[10]    = (rxq.size() == RXD);
    v[11]    = (txq.size() == 0);
    v[12]    = (txq.size() >= TXD / 2);
    v[13]    = (txq.size() == TXD);
    v[21:16] = m_ie;
    v[27:24] = 4'd3;
    v[31:28] = 4'd2;
    return v;
  endfunction

  function automatic bit exp_irq_rx();
    return m_en && ((m_ie[0] && rxq.size() > 0) || (m_ie[1] && rxq.size() >= RXD / 2)
                    || (m_ie[2] && rxq.size() == RXD));
  endfunction

  function automatic bit exp_irq_tx();
    return m_en && ((m_ie[3] && txq.size() == 0) || (m_ie[4] && txq.size() < TXD / 2)
                    || (m_ie[5] && txq.size() < TXD));
  endfunction

  task automatic check_irq();
    chk(irq_rx == exp_irq_rx(), "R10 irq_rx", 32'(irq_rx), 32'(exp_irq_rx()));
    chk(irq_tx == exp_irq_tx(), "R11 irq_tx", 32'(irq_tx), 32'(exp_irq_tx()));
  endtask

  // one bus cycle; entered and left at a falling edge
  task automatic bus_cycle(input bit we, input bit re, input logic [3:0] ofs,
                           input logic [31:0] wd);
    bus_addr  = ofs[3:2];
    bus_we    = we;
    bus_re    = re;
    bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    bus_re = 1'b0;
  endtask

  task automatic op_write_ctrl(input logic [31:0] v);
    bus_cycle(1'b1, 1'b0, 4'h0, v);
    m_en = v[0];
    m_ie = v[21:16];
    if (!m_en) begin
      rxq.delete(); txq.delete();
      m_pdata = '0; m_psrc = '0; m_plast = 1'b0;
    end else begin
      if (v[1]) rxq.delete();
      if (v[2]) txq.delete();
    end
    check_irq();
  endtask

  task automatic op_read_ctrl(input string req);
    logic [31:0] e = exp_ctrl();
    bus_cycle(1'b0, 1'b1, 4'h0, '0);
    chk(bus_rdata == e, req, bus_rdata, e);
    check_irq();
  endtask

  task automatic op_write_route(input logic [31:0] v);
    bus_cycle(1'b1, 1'b0, 4'h4, v);
    m_dest = v[3:0];
    check_irq();
  endtask

  task automatic op_read_route();
    logic [31:0] e = {24'b0, m_psrc, m_dest};
    bus_cycle(1'b0, 1'b1, 4'h4, '0);
    chk(bus_rdata == e, "R3 route readback", bus_rdata, e);
    check_irq();
  endtask

  task automatic op_tx_write(input bit last, input logic [31:0] d);
    bus_cycle(1'b1, 1'b0, last ? 4'hC : 4'h8, d);
    if (m_en && txq.size() < TXD) txq.push_back({last, m_dest, d});
    check_irq();
  endtask

  task automatic op_read_data(input bit use_c);
    logic [31:0] e;
    string req;
    if (rxq.size() > 0) begin
      e = rxq[0][31:0];
      m_pdata = e; m_psrc = rxq[0][35:32]; m_plast = rxq[0][36];
      void'(rxq.pop_front());
      req = "R3 rx pop data";
    end else begin
      e = m_pdata;
      req = "R5 empty read";
    end
    bus_cycle(1'b0, 1'b1, use_c ? 4'hC : 4'h8, '0);
    chk(bus_rdata == e, req, bus_rdata, e);
    check_irq();
  endtask

  task automatic op_rx_offer(input logic [31:0] d, input logic [3:0] t, input bit l);
    bit er = m_en && rxq.size() < RXD;
    rx_data = d; rx_tag = t; rx_last = l; rx_valid = 1'b1;
    chk(rx_ready == er, "R1 rx_ready", 32'(rx_ready), 32'(er));
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    if (er) rxq.push_back({l, t, d});
    check_irq();
  endtask

  task automatic op_tx_drain();
    bit ev = m_en && txq.size() > 0;
    tx_ready = 1'b1;
    chk(tx_valid == ev, "R1 tx_valid", 32'(tx_valid), 32'(ev));
    if (ev && tx_valid) begin
      chk({tx_last, tx_tag, tx_data} == txq[0], "R2 tx word",
          {tx_last, tx_tag, tx_data[23:0]}, {txq[0][36:32], txq[0][23:0]});
      chk(tx_data == txq[0][31:0], "R2 tx data", tx_data, txq[0][31:0]);
    end
    @(posedge clk);
    @(negedge clk);
    tx_ready = 1'b0;
    if (ev) void'(txq.pop_front());
    check_irq();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250317));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    chk(rx_ready == 1'b0, "R9 rx_ready off", 32'(rx_ready), 32'd0);
    chk(tx_valid == 1'b0, "R9 tx_valid off", 32'(tx_valid), 32'd0);
    op_read_ctrl("R12 reset ctrl R7");
    op_read_route();

    // enable, route field with junk in upper bits (R3: upper bits read zero)
    op_write_ctrl(32'h0000_0001);
    op_read_ctrl("R7 enabled ctrl");
    op_write_route(32'hFFFF_FF0A);
    op_read_route();

    // R4: overfill TX, then drain in order (R2)
    op_tx_write(1'b0, 32'h1111_0001);
    op_write_route(32'h3);
    op_tx_write(1'b1, 32'h1111_0002);
    op_tx_write(1'b0, 32'h1111_0003);
    op_tx_write(1'b1, 32'h1111_0004);
    op_read_ctrl("R6 tx full flags");
    op_tx_write(1'b0, 32'hDEAD_BEEF);
    op_read_ctrl("R4 tx still full");
    repeat (5) op_tx_drain();

    // R5: empty read before any pop returns zero
    op_read_data(1'b0);
    op_rx_offer(32'hA5A5_0001, 4'h6, 1'b0);
    op_rx_offer(32'hA5A5_0002, 4'h9, 1'b1);
    op_read_data(1'b0);
    op_read_ctrl("R3 last flag clear");
    op_read_data(1'b1);
    op_read_ctrl("R3 last flag set");
    op_read_route();
    op_read_data(1'b0);

    // R8: flush RX by clear bit, flush TX by clear bit
    repeat (3) op_rx_offer($urandom, 4'($urandom), 1'b0);
    op_tx_write(1'b0, 32'h7);
    op_write_ctrl(32'h0000_0003);
    op_read_ctrl("R8 rx flushed");
    op_write_ctrl(32'h0000_0005);
    op_read_ctrl("R8 tx flushed");

    // R6: fill RX to full and check half/full, R10 selects
    op_write_ctrl(32'h0007_0001);
    for (int i = 0; i < RXD + 1; i++) begin
      op_rx_offer(32'h5000_0000 + 32'(i), 4'(i), i[0]);
      op_read_ctrl("R6 rx levels");
    end

    // R9: disable flushes everything
    op_tx_write(1'b0, 32'h8);
    op_write_ctrl(32'h003F_0000);
    op_read_ctrl("R9 disabled flushed");
    op_rx_offer(32'h1, 4'h1, 1'b0);
    op_read_data(1'b0);
    op_write_ctrl(32'h0038_0001);

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      int r = int'($urandom % 16);
      case (r)
        0, 1, 2, 3: op_rx_offer($urandom, 4'($urandom), 1'($urandom));
        4, 5:       op_tx_drain();
        6, 7, 8:    op_tx_write(1'($urandom), $urandom);
        9, 10:      op_read_data(1'($urandom));
        11, 15:     op_read_ctrl("R6 R7 random ctrl");
        12:         op_read_route();
        13:         op_write_route($urandom);
        default: begin
          logic [31:0] v = $urandom & 32'h003F_0006;
          if (($urandom % 8) != 0) v[0] = 1'b1;
          if (($urandom % 4) != 0) v[2:1] = 2'b00;
          op_write_ctrl(v);
        end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule